// File: doc/BRIEF.md
# Interrupt Enable and Skip-Poll Unit

This block keeps a four-bit interrupt enable register and one request flag for each of four sources: timer 3, timer 5, the A/D converter, and a shared slot that carries either timer 4 or the serial port. A select input decides which of the two shared sources drives the slot.

The enable bit for a source decides how its flag is serviced. When the bit is set, the flag raises an interrupt request. A fixed-priority arbiter picks one granted source and reports its index. An acknowledge from the core clears the flag of that source. When the bit is clear, the source is serviced by polling instead. The core issues a skip-if-flag strobe for that source, and the block answers with a skip result in the same cycle. If the flag was set, the block also clears it. A poll strobe sent to an enabled source has no effect.

Software writes the enable register and reads it back over a four-bit bus. A power-down input forces the enable register to zero. The request flags keep their values through power-down.

Top module: `irq_poll_unit`

## Requirements
- R1: After reset the enable register and all flags are 0. With no stimulus, `irq_req`, `skip` and `reg_rdata` are 0.
- R2: A `reg_wr` pulse loads `reg_wdata` into the enable register at the next clock edge. While `reg_rd` is 1, `reg_rdata` shows the enable register. While `reg_rd` is 0, `reg_rdata` is 0.
- R3: `pwr_dn` clears the enable register at the next clock edge, even if a write arrives in the same cycle. The flags keep their values.
- R4: Each source has a fixed position, used for the enable bits, the poll strobes and `irq_idx`. Index 0 is timer 3, index 1 is timer 5, index 2 is the A/D converter, and index 3 is the shared slot.
- R5: If `slot3_sel` is 0, `tmr4_evt` feeds index 3. If `slot3_sel` is 1, `sio_evt` feeds index 3. The source that is not selected is ignored.
- R6: An event pulse sets its flag at the next clock edge, and the flag stays set until it is cleared. If a set and a clear happen in the same cycle, the set wins.
- R7: A poll of a source whose enable bit is 0 makes `skip` equal to that source's flag in the same cycle. A set flag is cleared at the next edge.
- R8: A poll of a source whose enable bit is 1 behaves as a no-op. It gives `skip` = 0 and leaves the flag unchanged.
- R9: `irq_req` is 1 in any cycle in which at least one source has both its flag and its enable bit set.
- R10: `irq_idx` is the lowest index among the sources that are both flagged and enabled.
- R11: `irq_ack` while `irq_req` is 1 clears only the flag at `irq_idx`, at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pwr_dn | input | 1 | Forces the enable register to zero |
| tmr3_evt | input | 1 | Timer 3 event pulse |
| tmr5_evt | input | 1 | Timer 5 event pulse |
| adc_evt | input | 1 | A/D conversion-done pulse |
| tmr4_evt | input | 1 | Timer 4 event pulse (shared slot) |
| sio_evt | input | 1 | Serial transfer-done pulse (shared slot) |
| slot3_sel | input | 1 | 0 selects timer 4 and 1 selects serial for index 3 |
| reg_wr | input | 1 | Enable register write strobe |
| reg_wdata | input | 4 | Write data |
| reg_rd | input | 1 | Enable register read strobe |
| reg_rdata | output | 4 | Read data |
| poll_req | input | 4 | One skip-if-flag strobe per source index |
| skip | output | 1 | Skip result of the current poll |
| irq_req | output | 1 | Interrupt request |
| irq_idx | output | 2 | Index of the granted source |
| irq_ack | input | 1 | Acknowledge of the granted interrupt |

## Verification
`skip`, `irq_req`, `irq_idx` and `reg_rdata` are combinational from the current inputs and the stored state, so each is due in the same cycle as its stimulus. Flag and enable updates appear one edge later. The bench drives its inputs on the falling edge and compares every output 1 ns later against a behavioural model. It then advances the model on the rising edge, so each check falls inside the cycle in which its result is due. Flag contents are observed through skip results and interrupt requests, never through internal signals.

// File: rtl/irq_poll_pkg.sv
package irq_poll_pkg;
   localparam int unsigned NUM_SRC = 4;
   localparam int unsigned IDX_W   = $clog2(NUM_SRC);

   // fixed source positions; enable bits, poll strobes and grant index share them
   localparam int unsigned SRC_TMR3  = 0;
   localparam int unsigned SRC_TMR5  = 1;
   localparam int unsigned SRC_ADC   = 2;
   localparam int unsigned SRC_SHARE = 3;

   typedef logic [NUM_SRC-1:0] src_vec_t;
   typedef logic [IDX_W-1:0]   src_idx_t;

   typedef enum logic {
      SHARE_TMR4 = 1'b0,
      SHARE_SIO  = 1'b1
   } share_sel_e;
endpackage

// File: rtl/irq_en_reg.sv
module irq_en_reg #(
   parameter int unsigned WIDTH      = 4,
   parameter bit          GATE_RDATA = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pwr_dn,
   input  logic             wr,
   input  logic [WIDTH-1:0] wdata,
   input  logic             rd,
   output logic [WIDTH-1:0] rdata,
   output logic [WIDTH-1:0] en_q
);
   localparam logic [WIDTH-1:0] EN_CLEAR = '0;

   generate
      if (WIDTH < 1) begin : g_bad_width
         $error("irq_en_reg: WIDTH must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)      en_q <= EN_CLEAR;
      else if (pwr_dn) en_q <= EN_CLEAR;
      else if (wr)     en_q <= wdata;
   end

   generate
      if (GATE_RDATA) begin : g_rd_gated
         always_comb rdata = rd ? en_q : EN_CLEAR;
      end else begin : g_rd_open
         logic unused_rd;
         always_comb begin
            rdata     = en_q;
            unused_rd = rd;
         end
      end
   endgenerate

   AST_PWRDN_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      pwr_dn |=> (en_q == EN_CLEAR)); // R3
   AST_WRITE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && !pwr_dn) |=> (en_q == $past(wdata))); // R2
   AST_EN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr && !pwr_dn) |=> $stable(en_q)); // R2
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
   parameter int unsigned NUM = 4
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [NUM-1:0] set_vec,
   input  logic [NUM-1:0] clr_vec,
   output logic [NUM-1:0] flag_q
);
   generate
      if (NUM < 1) begin : g_bad_num
         $error("irq_flag_bank: NUM must be at least 1");
      end
      for (genvar g = 0; g < NUM; g++) begin : g_flag
         always_ff @(posedge clk) begin
            if (!rst_n)          flag_q[g] <= 1'b0;
            else if (set_vec[g]) flag_q[g] <= 1'b1;   // new event beats clear
            else if (clr_vec[g]) flag_q[g] <= 1'b0;
         end

         AST_SET_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
            set_vec[g] |=> flag_q[g]); // R6
         AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_vec[g] && !set_vec[g]) |=> !flag_q[g]); // R7
         AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
            (!clr_vec[g] && !set_vec[g]) |=> $stable(flag_q[g])); // R6
      end
   endgenerate
endmodule

// File: rtl/irq_prio_arb.sv
module irq_prio_arb #(
   parameter int unsigned NUM       = 4,
   parameter bit          LOW_FIRST = 1'b1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [NUM-1:0]         req_vec,
   output logic                   any_req,
   output logic [NUM-1:0]         grant,
   output logic [$clog2(NUM)-1:0] grant_idx
);
   localparam int unsigned IW = $clog2(NUM);

   generate
      if (NUM < 2) begin : g_bad_num
         $error("irq_prio_arb: NUM must be at least 2");
      end
      if (LOW_FIRST) begin : g_low_first
         always_comb begin
            grant     = '0;
            grant_idx = '0;
            for (int i = NUM - 1; i >= 0; i--) begin
               if (req_vec[i]) begin
                  grant     = '0;
                  grant[i]  = 1'b1;
                  grant_idx = IW'(i);
               end
            end
         end
      end else begin : g_high_first
         always_comb begin
            grant     = '0;
            grant_idx = '0;
            for (int i = 0; i < NUM; i++) begin
               if (req_vec[i]) begin
                  grant     = '0;
                  grant[i]  = 1'b1;
                  grant_idx = IW'(i);
               end
            end
         end
      end
   endgenerate

   always_comb any_req = |req_vec;

   AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant)); // R10
   AST_GRANT_IFF_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      any_req == (grant != '0)); // R9
   AST_GRANT_IN_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      (grant & ~req_vec) == '0); // R10
endmodule

// File: rtl/irq_poll_unit.sv
module irq_poll_unit
   import irq_poll_pkg::*;
#(
   parameter bit PRIO_LOW_FIRST = 1'b1,
   parameter bit GATE_RDATA     = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               pwr_dn,
   input  logic               tmr3_evt,
   input  logic               tmr5_evt,
   input  logic               adc_evt,
   input  logic               tmr4_evt,
   input  logic               sio_evt,
   input  logic               slot3_sel,
   input  logic               reg_wr,
   input  logic [NUM_SRC-1:0] reg_wdata,
   input  logic               reg_rd,
   output logic [NUM_SRC-1:0] reg_rdata,
   input  logic [NUM_SRC-1:0] poll_req,
   output logic               skip,
   output logic               irq_req,
   output logic [IDX_W-1:0]   irq_idx,
   input  logic               irq_ack
);
   src_vec_t en_q, flag_q, set_vec, clr_vec, poll_hit, ack_clr, grant, pend;
   share_sel_e share_sel;

   generate
      if (NUM_SRC != 4) begin : g_bad_cfg
         $error("irq_poll_unit: port set assumes four sources");
      end
   endgenerate

   // shared slot selection (R5), fixed positions (R4)
   always_comb begin
      share_sel           = share_sel_e'(slot3_sel);
      set_vec             = '0;
      set_vec[SRC_TMR3]   = tmr3_evt;
      set_vec[SRC_TMR5]   = tmr5_evt;
      set_vec[SRC_ADC]    = adc_evt;
      set_vec[SRC_SHARE]  = (share_sel == SHARE_SIO) ? sio_evt : tmr4_evt;
   end

   // poll is live only for disabled sources (R7, R8)
   always_comb begin
      poll_hit = poll_req & ~en_q & flag_q;
      skip     = |poll_hit;
      pend     = flag_q & en_q;
      ack_clr  = (irq_ack && irq_req) ? grant : '0;
      clr_vec  = poll_hit | ack_clr;
   end

   irq_en_reg #(
      .WIDTH      (NUM_SRC),
      .GATE_RDATA (GATE_RDATA)
   ) u_en (
      .clk   (clk),
      .rst_n (rst_n),
      .pwr_dn(pwr_dn),
      .wr    (reg_wr),
      .wdata (reg_wdata),
      .rd    (reg_rd),
      .rdata (reg_rdata),
      .en_q  (en_q)
   );

   irq_flag_bank #(.NUM(NUM_SRC)) u_flags (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_vec(set_vec),
      .clr_vec(clr_vec),
      .flag_q (flag_q)
   );

   irq_prio_arb #(
      .NUM      (NUM_SRC),
      .LOW_FIRST(PRIO_LOW_FIRST)
   ) u_arb (
      .clk      (clk),
      .rst_n    (rst_n),
      .req_vec  (pend),
      .any_req  (irq_req),
      .grant    (grant),
      .grant_idx(irq_idx)
   );

   AST_SKIP_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      skip |-> (flag_q != '0)); // R7
   AST_POLL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (skip && !irq_ack && set_vec == '0) |=> ($countones(flag_q) < $countones($past(flag_q)))); // R7
   AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_ack && irq_req && set_vec == '0) |=> !flag_q[$past(irq_idx)]); // R11
   AST_REQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> (en_q != '0)); // R9
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q == '0) |-> (!irq_req && !skip)); // R1
endmodule

// File: tb/irq_poll_unit_tb.sv
`timescale 1ns/1ps
module irq_poll_unit_tb_top;
   localparam real CYC = 5.0;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic pwr_dn = 0, tmr3_evt = 0, tmr5_evt = 0, adc_evt = 0, tmr4_evt = 0, sio_evt = 0;
   logic slot3_sel = 0, reg_wr = 0, reg_rd = 0, irq_ack = 0;
   logic [3:0] reg_wdata = '0, poll_req = '0;
   logic [3:0] reg_rdata;
   logic skip, irq_req;
   logic [1:0] irq_idx;

   int total = 0;
   int bad = 0;
   bit done = 0;

   logic [3:0] m_en, m_flag;

   always #(CYC/2) clk = ~clk;

   irq_poll_unit dut_i (
      .clk(clk), .rst_n(rst_n), .pwr_dn(pwr_dn),
      .tmr3_evt(tmr3_evt), .tmr5_evt(tmr5_evt), .adc_evt(adc_evt),
      .tmr4_evt(tmr4_evt), .sio_evt(sio_evt), .slot3_sel(slot3_sel),
      .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
      .poll_req(poll_req), .skip(skip), .irq_req(irq_req), .irq_idx(irq_idx),
      .irq_ack(irq_ack)
   );

   task automatic chk(input string tag, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic logic [3:0] ev_vec();
      logic [3:0] v;
      v[0] = tmr3_evt;
      v[1] = tmr5_evt;
      v[2] = adc_evt;
      v[3] = slot3_sel ? sio_evt : tmr4_evt;
      return v;
   endfunction

   // one cycle: inputs already driven after negedge; compare, then advance model at posedge
   task automatic step(input string tag);
      logic [3:0] pend, hit, clr;
      int idx;
      #1;
      pend = m_flag & m_en;
      hit  = poll_req & ~m_en & m_flag;
      idx  = 0;
      for (int i = 3; i >= 0; i--) if (pend[i]) idx = i;
      chk({tag, " R9 irq_req"}, int'(irq_req), int'(pend != 0));
      if (pend != 0) chk({tag, " R10 irq_idx"}, int'(irq_idx), idx);
      chk({tag, " R7/R8 skip"}, int'(skip), int'(hit != 0));
      chk({tag, " R2 rdata"}, int'(reg_rdata), int'(reg_rd ? m_en : 4'd0));
      clr = hit;
      if (irq_ack && pend != 0) clr[idx] = 1'b1;
      @(posedge clk);
      m_flag = (m_flag & ~clr) | ev_vec();
      if (pwr_dn) m_en = 4'd0;
      else if (reg_wr) m_en = reg_wdata;
      @(negedge clk);
      {pwr_dn, tmr3_evt, tmr5_evt, adc_evt, tmr4_evt, sio_evt, reg_wr, reg_rd, irq_ack} = '0;
      poll_req = '0;
   endtask

   task automatic wr_en(input logic [3:0] v);
      reg_wr = 1; reg_wdata = v; step("wr");
   endtask

   // poll one source and check skip explicitly
   task automatic poll(input int i, input bit exp_skip, input string tag);
      poll_req = 4'b1 << i;
      #1 chk(tag, int'(skip), int'(exp_skip));
      step(tag);
   endtask

   initial begin
      m_en = 0; m_flag = 0;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 irq_req", int'(irq_req), 0);
      chk("R1 skip", int'(skip), 0);
      reg_rd = 1;
      #1 chk("R1 rdata", int'(reg_rdata), 0);
      rst_n = 1;
      @(negedge clk);
      reg_rd = 1; step("R1 idle");

      // R2 write and read back
      wr_en(4'b1010);
      reg_rd = 1; #1 chk("R2 readback", int'(reg_rdata), 10); step("R2 rd");
      #1 chk("R2 no rd", int'(reg_rdata), 0); step("R2 idle");

      // R3 power-down beats write, flags kept
      tmr5_evt = 1; step("R3 prep");
      pwr_dn = 1; reg_wr = 1; reg_wdata = 4'b1111; step("R3 pd");
      reg_rd = 1; #1 chk("R3 en cleared", int'(reg_rdata), 0); step("R3 rd");
      wr_en(4'b0010);
      #1 chk("R3 flag kept -> irq", int'(irq_req), 1); step("R3 irq");
      wr_en(4'b0000);
      poll(1, 1, "R3 flag kept poll");

      // R7 / R8: disabled poll skips and clears, enabled poll is no-op
      adc_evt = 1; step("R7 set");
      poll(2, 1, "R7 poll hit");
      poll(2, 0, "R7 flag cleared");
      adc_evt = 1; step("R8 set");
      wr_en(4'b0100);
      poll(2, 0, "R8 enabled poll nop");
      #1 chk("R8 flag unchanged", int'(irq_req), 1); chk("R4 adc index", int'(irq_idx), 2); step("R8 irq");
      wr_en(4'b0000);
      poll(2, 1, "R8 flag still set");

      // R5 shared slot select
      slot3_sel = 0; sio_evt = 1; step("R5 sio ignored");
      poll(3, 0, "R5 unselected ignored");
      tmr4_evt = 1; step("R5 tmr4");
      poll(3, 1, "R5 tmr4 feeds slot");
      slot3_sel = 1; tmr4_evt = 1; step("R5 tmr4 ignored");
      poll(3, 0, "R5 tmr4 ignored when sio selected");
      sio_evt = 1; step("R5 sio");
      poll(3, 1, "R5 sio feeds slot");

      // R6 set wins over poll clear in same cycle
      tmr3_evt = 1; step("R6 set");
      tmr3_evt = 1; poll(0, 1, "R6 set and poll");
      poll(0, 1, "R6 set won");

      // R10 priority, R11 ack clears only granted
      tmr3_evt = 1; tmr5_evt = 1; adc_evt = 1; step("R10 set3");
      wr_en(4'b1111);
      #1 chk("R10 lowest wins", int'(irq_idx), 0); irq_ack = 1; step("R11 ack0");
      #1 chk("R11 next idx", int'(irq_idx), 1); irq_ack = 1; step("R11 ack1");
      #1 chk("R11 idx2", int'(irq_idx), 2); chk("R4 idx A/D", int'(irq_idx), 2); irq_ack = 1; step("R11 ack2");
      #1 chk("R11 all clear", int'(irq_req), 0); step("R11 idle");

      // mixed random traffic against the model
      for (int n = 0; n < 3000; n++) begin
         {tmr3_evt, tmr5_evt, adc_evt, tmr4_evt, sio_evt} = 5'($urandom) & 5'($urandom);
         slot3_sel = 1'($urandom);
         reg_wr    = ($urandom % 6) == 0;
         reg_wdata = 4'($urandom);
         reg_rd    = 1'($urandom);
         pwr_dn    = ($urandom % 40) == 0;
         poll_req  = 4'b1 << ($urandom % 4);
         if (($urandom % 2) == 0) poll_req = '0;
         irq_ack   = 1'($urandom);
         step("rand");
      end

      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(CYC * 100000);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog R1 actual=hung expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule